// File: doc/BRIEF.md
# Scaler mode and line-buffer selector

This block turns one plane geometry request into the setup of an image-plane scaler. From the source and destination sizes, it works out the scaling direction for each axis. A YUV flag and two chroma subsampling divisors tell it whether the request also has a chroma plane and how large that plane is. It picks one of six line-buffer partitions. That partition decides whether vertical upscaling uses a bicubic or a bilinear filter, or whether vertical scaling is forbidden. It also raises a single error flag for any ratio or size the scaler cannot handle.

The block does not compute fixed-point step factors and does not filter pixels. A caller presents the sizes and pulses `start`. One cycle later `done` pulses and the registered results appear. The results, including the error flag, stay as they are until the next `start`. All pins are plain control and status pins. There is no streamed data and no back-pressure: the inputs only need to be valid in the cycle where `start` is high.

Top module: `scl_cfg_sel`

## Requirements
- R1: A `start` sampled high at a clock edge loads every result at that edge, so `done` is high for exactly the following cycle. With `start` held high, `done` stays high. Without `start`, all results, including `cfg_err`, hold their values however the inputs change.
- R2: Each luma direction output encodes none=0, up=1, down=2. It is up when the source dimension is below the destination, down when it is above, and none when they are equal.
- R3: With `is_yuv`=1, the chroma source width is `src_w/hsub` and the chroma source height is `src_h/vsub`, where a divisor of 0 counts as 1. The chroma destination is the luma destination. Chroma directions follow the rule of R2. With `is_yuv`=0, both chroma directions are none.
- R4: `cfg_err` is set when `dst_w*8 <= src_w`, or when `dst_h*8 <= src_h`, or when `dst_w > 3840`.
- R5: With `is_yuv`=1, `cfg_err` is also set when the chroma source width is 0 or above 3840, or when the chroma ratio test of R4 fails on either axis.
- R6: With `is_yuv`=0, the reference width is `dst_w` when luma is horizontally downscaled, and `src_w` otherwise. `lb_code` is 2 above 2560, 3 above 1920, and 4 otherwise.
- R7: With `is_yuv`=1, `lb_code` is 2 if luma is horizontally downscaled with `dst_w > 2560`. Otherwise the reference width is `dst_w` if chroma is horizontally downscaled, and the chroma source width if not. That reference width gives 2 above 2560, 3 above 1920, 0 above 1280, and 1 otherwise.
- R8: `vup_bicubic` is 1 for `lb_code` 0, 1, 4 or 5, and 0 for `lb_code` 2 or 3.
- R9: With `lb_code`=2, `cfg_err` is set if any luma or chroma vertical direction is not none.
- R10: When `vup_bicubic`=1, `cfg_err` is set if a plane upscaled vertically has a source height below 3. The luma source height applies to luma, and the chroma source height to chroma.
- R11: After reset, `done`, all direction outputs, `lb_code`, `vup_bicubic` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Evaluate the present inputs at this edge |
| src_w | input | W | Luma/RGB source width |
| src_h | input | W | Luma/RGB source height |
| dst_w | input | W | Destination width |
| dst_h | input | W | Destination height |
| is_yuv | input | 1 | Format carries a chroma plane |
| hsub | input | SUB_W | Horizontal chroma divisor (0 treated as 1) |
| vsub | input | SUB_W | Vertical chroma divisor (0 treated as 1) |
| done | output | 1 | Results updated in the previous edge |
| y_hdir | output | 2 | Luma horizontal direction |
| y_vdir | output | 2 | Luma vertical direction |
| c_hdir | output | 2 | Chroma horizontal direction |
| c_vdir | output | 2 | Chroma vertical direction |
| lb_code | output | 3 | Line-buffer partition code |
| vup_bicubic | output | 1 | Vertical upscale filter: 1 bicubic, 0 bilinear |
| cfg_err | output | 1 | Illegal ratio, size or mode combination |

## Verification
The bench builds the block with its defaults: 16-bit sizes, 3-bit divisors, a ratio shift of 3, a width limit of 3840 and thresholds of 2560, 1920 and 1280. The 16-bit sizes let it place widths just on and just past each threshold and the limit, such as 3840 against 3841 and 2560 against 2561. The 3-bit divisors reach the zero divisor, and a divisor of 4 that drives the chroma width to zero. Heights of 2 and 3 probe the bicubic minimum, and a ratio of exactly 8 probes the ratio edge.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    SDIR_NONE = 2'd0,
    SDIR_UP   = 2'd1,
    SDIR_DOWN = 2'd2
  } sdir_e;

  // Line-buffer partitions: codes are decoded by the scaler datapath.
  typedef enum logic [2:0] {
    LBP_YUV_W3840 = 3'd0,
    LBP_YUV_W2560 = 3'd1,
    LBP_RGB_W3840 = 3'd2,
    LBP_RGB_W2560 = 3'd3,
    LBP_RGB_W1920 = 3'd4,
    LBP_RGB_W1280 = 3'd5
  } lbp_e;

  function automatic logic lbp_bicubic(input logic [2:0] code);
    return (code == LBP_YUV_W3840) || (code == LBP_YUV_W2560) ||
           (code == LBP_RGB_W1920) || (code == LBP_RGB_W1280);
  endfunction

  function automatic logic lbp_no_vscale(input logic [2:0] code);
    return code == LBP_RGB_W3840;
  endfunction

endpackage

// File: rtl/scl_axis_dir.sv
module scl_axis_dir #(
  parameter int W = 16
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [1:0]   dir
);
  import scl_pkg::*;

  always_comb begin
    if (src < dst)      dir = SDIR_UP;
    else if (src > dst) dir = SDIR_DOWN;
    else                dir = SDIR_NONE;
  end

endmodule

// File: rtl/scl_ratio_chk.sv
module scl_ratio_chk #(
  parameter int W           = 16,
  parameter int RATIO_SHIFT = 3,
  parameter int MAX_W       = 3840,
  parameter bit LIMIT_SRC   = 1'b0
) (
  input  logic [W-1:0] src_w,
  input  logic [W-1:0] src_h,
  input  logic [W-1:0] dst_w,
  input  logic [W-1:0] dst_h,
  output logic         bad
);
  localparam int XW = W + RATIO_SHIFT;
  localparam logic [W-1:0] MAX_V = W'(MAX_W);

  logic [XW-1:0] dw_x, dh_x, sw_x, sh_x;
  logic          ratio_bad, lim_bad;

  assign dw_x = {dst_w, {RATIO_SHIFT{1'b0}}};
  assign dh_x = {dst_h, {RATIO_SHIFT{1'b0}}};
  assign sw_x = XW'(src_w);
  assign sh_x = XW'(src_h);

  assign ratio_bad = (dw_x <= sw_x) || (dh_x <= sh_x);

  generate
    if (LIMIT_SRC) begin : g_src_lim
      assign lim_bad = (src_w > MAX_V) || (src_w == '0);
    end else begin : g_dst_lim
      assign lim_bad = dst_w > MAX_V;
    end
  endgenerate

  assign bad = ratio_bad || lim_bad;

endmodule

// File: rtl/scl_lb_pick.sv
module scl_lb_pick #(
  parameter int W     = 16,
  parameter int TH_HI = 2560,
  parameter int TH_MD = 1920,
  parameter int TH_LO = 1280
) (
  input  logic         yuv,
  input  logic         y_hdown,
  input  logic [W-1:0] y_src_w,
  input  logic [W-1:0] y_dst_w,
  input  logic         c_hdown,
  input  logic [W-1:0] c_src_w,
  output logic [2:0]   code
);
  import scl_pkg::*;

  localparam logic [W-1:0] HI_V = W'(TH_HI);
  localparam logic [W-1:0] MD_V = W'(TH_MD);
  localparam logic [W-1:0] LO_V = W'(TH_LO);

  logic [W-1:0] y_ref, c_ref;

  assign y_ref = y_hdown ? y_dst_w : y_src_w;
  assign c_ref = c_hdown ? y_dst_w : c_src_w;

  always_comb begin
    if (!yuv) begin
      if (y_ref > HI_V)      code = LBP_RGB_W3840;
      else if (y_ref > MD_V) code = LBP_RGB_W2560;
      else                   code = LBP_RGB_W1920;
    end else if (y_hdown && (y_dst_w > HI_V)) begin
      code = LBP_RGB_W3840;
    end else begin
      if (c_ref > HI_V)      code = LBP_RGB_W3840;
      else if (c_ref > MD_V) code = LBP_RGB_W2560;
      else if (c_ref > LO_V) code = LBP_YUV_W3840;
      else                   code = LBP_YUV_W2560;
    end
  end

endmodule

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel
  import scl_pkg::*;
#(
  parameter int W           = 16,
  parameter int SUB_W       = 3,
  parameter int RATIO_SHIFT = 3,
  parameter int MAX_W       = 3840,
  parameter int TH_HI       = 2560,
  parameter int TH_MD       = 1920,
  parameter int TH_LO       = 1280,
  parameter int MIN_BIC_H   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     src_w,
  input  logic [W-1:0]     src_h,
  input  logic [W-1:0]     dst_w,
  input  logic [W-1:0]     dst_h,
  input  logic             is_yuv,
  input  logic [SUB_W-1:0] hsub,
  input  logic [SUB_W-1:0] vsub,
  output logic             done,
  output logic [1:0]       y_hdir,
  output logic [1:0]       y_vdir,
  output logic [1:0]       c_hdir,
  output logic [1:0]       c_vdir,
  output logic [2:0]       lb_code,
  output logic             vup_bicubic,
  output logic             cfg_err
);
  localparam int NAX = 4;
  localparam logic [W-1:0] MIN_H_V = W'(MIN_BIC_H);
  localparam logic [W-1:0] MAX_V   = W'(MAX_W);

  // Chroma plane source size (divisor 0 behaves as 1)
  logic [SUB_W-1:0] hdiv, vdiv;
  logic [W-1:0]     c_src_w, c_src_h;

  assign hdiv    = (hsub == '0) ? SUB_W'(1) : hsub;
  assign vdiv    = (vsub == '0) ? SUB_W'(1) : vsub;
  assign c_src_w = src_w / W'(hdiv);
  assign c_src_h = src_h / W'(vdiv);

  // Per-axis direction: 0 luma h, 1 luma v, 2 chroma h, 3 chroma v
  logic [W-1:0] ax_src [NAX];
  logic [W-1:0] ax_dst [NAX];
  logic [1:0]   ax_dir [NAX];

  assign ax_src[0] = src_w;
  assign ax_src[1] = src_h;
  assign ax_src[2] = c_src_w;
  assign ax_src[3] = c_src_h;
  assign ax_dst[0] = dst_w;
  assign ax_dst[1] = dst_h;
  assign ax_dst[2] = dst_w;
  assign ax_dst[3] = dst_h;

  generate
    for (genvar g = 0; g < NAX; g++) begin : g_axis
      scl_axis_dir #(.W(W)) u_dir (
        .src (ax_src[g]),
        .dst (ax_dst[g]),
        .dir (ax_dir[g])
      );
    end
  endgenerate

  logic [1:0] yh_n, yv_n, ch_n, cv_n;
  assign yh_n = ax_dir[0];
  assign yv_n = ax_dir[1];
  assign ch_n = is_yuv ? ax_dir[2] : SDIR_NONE;
  assign cv_n = is_yuv ? ax_dir[3] : SDIR_NONE;

  // Size and ratio checks
  logic y_bad, c_bad;

  scl_ratio_chk #(.W(W), .RATIO_SHIFT(RATIO_SHIFT), .MAX_W(MAX_W), .LIMIT_SRC(1'b0)) u_ychk (
    .src_w (src_w),
    .src_h (src_h),
    .dst_w (dst_w),
    .dst_h (dst_h),
    .bad   (y_bad)
  );

  scl_ratio_chk #(.W(W), .RATIO_SHIFT(RATIO_SHIFT), .MAX_W(MAX_W), .LIMIT_SRC(1'b1)) u_cchk (
    .src_w (c_src_w),
    .src_h (c_src_h),
    .dst_w (dst_w),
    .dst_h (dst_h),
    .bad   (c_bad)
  );

  // Line-buffer partition
  logic [2:0] lb_n;

  scl_lb_pick #(.W(W), .TH_HI(TH_HI), .TH_MD(TH_MD), .TH_LO(TH_LO)) u_lb (
    .yuv     (is_yuv),
    .y_hdown (yh_n == SDIR_DOWN),
    .y_src_w (src_w),
    .y_dst_w (dst_w),
    .c_hdown (ch_n == SDIR_DOWN),
    .c_src_w (c_src_w),
    .code    (lb_n)
  );

  // Filter choice and mode-dependent errors
  logic bic_n, vscale_any, short_y, short_c, err_n;

  assign bic_n      = lbp_bicubic(lb_n);
  assign vscale_any = (yv_n != SDIR_NONE) || (cv_n != SDIR_NONE);
  assign short_y    = (yv_n == SDIR_UP) && (src_h < MIN_H_V);
  assign short_c    = (cv_n == SDIR_UP) && (c_src_h < MIN_H_V);
  assign err_n      = y_bad || (is_yuv && c_bad) ||
                      (lbp_no_vscale(lb_n) && vscale_any) ||
                      (bic_n && (short_y || short_c));

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      y_hdir      <= SDIR_NONE;
      y_vdir      <= SDIR_NONE;
      c_hdir      <= SDIR_NONE;
      c_vdir      <= SDIR_NONE;
      lb_code     <= 3'd0;
      vup_bicubic <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        y_hdir      <= yh_n;
        y_vdir      <= yv_n;
        c_hdir      <= ch_n;
        c_vdir      <= cv_n;
        lb_code     <= lb_n;
        vup_bicubic <= bic_n;
        cfg_err     <= err_n;
      end
    end
  end

  // Assertions
  assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  assert_hold_without_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> $stable({y_hdir, y_vdir, c_hdir, c_vdir, lb_code, vup_bicubic, cfg_err}));

  assert_hdir_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(src_w) < $past(dst_w))) |-> (y_hdir == SDIR_UP));

  assert_rgb_no_chroma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(is_yuv)) |-> (c_hdir == SDIR_NONE && c_vdir == SDIR_NONE));

  assert_wide_dst_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(dst_w) > MAX_V)) |-> cfg_err);

  assert_rgb_lb_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(is_yuv)) |-> (lb_code >= 3'd2 && lb_code <= 3'd4));

  assert_lb_wide_no_vscale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lb_code == 3'd2 && (y_vdir != SDIR_NONE || c_vdir != SDIR_NONE)) |-> cfg_err);

  assert_filter_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (lb_code == 3'd2 || lb_code == 3'd3)) |-> !vup_bicubic);

endmodule

// File: tb/tb_scl_cfg_sel.sv
`timescale 1ns/1ps
module tb_scl_cfg_sel;

  localparam int W = 16;
  localparam int SUB_W = 3;

  typedef struct packed {
    logic [15:0] sw, sh, dw, dh;
    logic        yuv;
    logic [2:0]  hs, vs;
    logic [1:0]  lh, lv, ch, cv;
    logic [2:0]  lb;
    logic        bic, err;
  } vec_t;

  localparam int NV = 23;
  // sw, sh, dw, dh, yuv, hs, vs | lh, lv, ch, cv, lb, bic, err
  localparam vec_t VT [NV] = '{
    '{1920, 1080, 1920, 1080, 0, 2, 2, 0, 0, 0, 0, 4, 1, 0}, // R2 R3 R6
    '{1280,  720, 1920, 1080, 0, 0, 0, 1, 1, 0, 0, 4, 1, 0}, // R2 R6
    '{3840, 2160, 1920, 1080, 0, 0, 0, 2, 2, 0, 0, 4, 1, 0}, // R2 R6 dst ref
    '{2200,  100, 2400,  100, 0, 0, 0, 1, 0, 0, 0, 3, 0, 0}, // R6 R8
    '{3000,  100, 3000,  100, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0}, // R6 R9 ok
    '{3000,  100, 3000,  200, 0, 0, 0, 0, 1, 0, 0, 2, 0, 1}, // R9
    '{1000,    2, 1000,    4, 0, 0, 0, 0, 1, 0, 0, 4, 1, 1}, // R10
    '{ 800,    3,  800,    6, 0, 0, 0, 0, 1, 0, 0, 4, 1, 0}, // R10 edge
    '{ 800,  100,  100,  100, 0, 0, 0, 2, 0, 0, 0, 4, 1, 1}, // R4 ratio 8
    '{ 799,  100,  100,  100, 0, 0, 0, 2, 0, 0, 0, 4, 1, 0}, // R4 just inside
    '{3841,   10, 3841,   10, 0, 0, 0, 0, 0, 0, 0, 2, 0, 1}, // R4 width
    '{3840,   10, 3840,   10, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0}, // R4 edge
    '{1920, 1080, 1920, 1080, 1, 2, 2, 0, 0, 1, 1, 1, 1, 0}, // R3 R7
    '{3840, 2160, 3840, 2160, 1, 2, 2, 0, 0, 1, 1, 0, 1, 0}, // R7
    '{3840, 2160, 2800, 1000, 1, 2, 2, 2, 2, 1, 2, 2, 0, 1}, // R7 R9
    '{3840,  100, 2000,  100, 1, 1, 1, 2, 0, 2, 0, 3, 0, 0}, // R7 chroma down
    '{4000,  100, 3000,  100, 1, 1, 1, 2, 0, 2, 0, 2, 0, 1}, // R5 wide chroma
    '{1000,   50, 1000,   50, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0}, // R3 div 0
    '{   3,   50,    3,   50, 1, 4, 1, 0, 0, 1, 0, 1, 1, 1}, // R5 zero chroma
    '{ 100,    4,  100,    8, 1, 1, 2, 0, 1, 0, 1, 1, 1, 1}, // R10 chroma
    '{2000,    2, 2000,    4, 1, 1, 1, 0, 1, 0, 1, 3, 0, 0}, // R8 bilinear
    '{2600,  100, 2500,  100, 1, 2, 1, 2, 0, 1, 0, 0, 1, 0}, // R7 src ref
    '{3000,  100, 2561,  100, 1, 1, 1, 2, 0, 2, 0, 2, 0, 0}  // R7 edge
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [W-1:0]     src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic             is_yuv = 1'b0;
  logic [SUB_W-1:0] hsub = '0, vsub = '0;
  logic             done;
  logic [1:0]       y_hdir, y_vdir, c_hdir, c_vdir;
  logic [2:0]       lb_code;
  logic             vup_bicubic, cfg_err;

  int nchk = 0;
  int nerr = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  scl_cfg_sel dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .is_yuv(is_yuv), .hsub(hsub), .vsub(vsub),
    .done(done), .y_hdir(y_hdir), .y_vdir(y_vdir), .c_hdir(c_hdir), .c_vdir(c_vdir),
    .lb_code(lb_code), .vup_bicubic(vup_bicubic), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src_w = v.sw; src_h = v.sh; dst_w = v.dw; dst_h = v.dh;
    is_yuv = v.yuv; hsub = v.hs; vsub = v.vs;
  endtask

  task automatic check_out(input int idx, input vec_t v);
    string s;
    s = $sformatf("vec%0d", idx);
    chk({s, " R2 luma h"}, y_hdir, v.lh);
    chk({s, " R2 luma v"}, y_vdir, v.lv);
    chk({s, " R3 chroma h"}, c_hdir, v.ch);
    chk({s, " R3 chroma v"}, c_vdir, v.cv);
    chk({s, " R6/R7 lb_code"}, lb_code, v.lb);
    chk({s, " R8 filter"}, vup_bicubic, v.bic);
    chk({s, " R4/R5/R9/R10 err"}, cfg_err, v.err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 dirs", {y_hdir, y_vdir, c_hdir, c_vdir}, 0);
    chk("R11 lb", lb_code, 0);
    chk("R11 bic/err", {vup_bicubic, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 done after release", done, 0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk($sformatf("vec%0d R1 done pulse", i), done, 1);
      check_out(i, VT[i]);
      @(negedge clk);
      chk($sformatf("vec%0d R1 done drop", i), done, 0);
      chk($sformatf("vec%0d R1 hold lb", i), lb_code, VT[i].lb);
    end

    // R1 hold: error result survives input changes without start
    drive(VT[5]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive(VT[0]);
    repeat (3) @(negedge clk);
    chk("R1 sticky err", cfg_err, 1);
    chk("R1 held lb", lb_code, 2);
    chk("R1 held vdir", y_vdir, 1);
    chk("R1 no done", done, 0);

    // R1 back-to-back starts
    drive(VT[1]);
    start = 1'b1;
    @(negedge clk);
    chk("R1 b2b first done", done, 1);
    chk("R1 b2b first hdir", y_hdir, 1);
    chk("R1 b2b first err", cfg_err, 0);
    drive(VT[4]);
    @(negedge clk);
    start = 1'b0;
    chk("R1 b2b second done", done, 1);
    chk("R1 b2b second lb", lb_code, 2);
    chk("R1 b2b second hdir", y_hdir, 0);
    @(negedge clk);
    chk("R1 b2b done drop", done, 0);

    // R11 reset in mid-use clears results
    drive(VT[14]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 pre-reset err", cfg_err, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears err", cfg_err, 0);
    chk("R11 reset clears lb", lb_code, 0);
    chk("R11 reset clears dirs", {y_hdir, y_vdir, c_hdir, c_vdir}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule